// File: doc/BRIEF.md
# Rate-Paced Clock-Crossing Sample Buffer

This block carries audio samples from a filter clock domain into a modulator clock domain. The producer writes whenever it has a sample, which means it writes in bursts separated by idle gaps. The consumer needs a steady stream. The block stores the samples in a small dual-clock FIFO and releases them on the read side at a fixed integer interval of `PERIOD` destination clocks. It never releases a sample simply because one is available. Because the output cadence is fixed, the burst pattern of the producer never shows up in the timing of the consumer.

The read side is controlled by a two-state machine:

- `PACE_FILL` is the state after reset. The block waits here until its own view of the FIFO level reaches half the depth.
- The transition **arm** moves the machine from `PACE_FILL` to `PACE_RUN`. On arm, the interval counter starts from zero.
- In `PACE_RUN`, a pacing tick comes every `PERIOD` cycles. The transition **hold** keeps the machine in `PACE_RUN` indefinitely.
- The transition **reset** is the only way back to `PACE_FILL`.

On each tick the block pops one sample. If the FIFO is empty at that tick, the block repeats the previous sample instead, so the cadence never breaks, and it sets a sticky underflow flag. A write that arrives while the FIFO is full is discarded and sets a sticky overflow flag in the write domain.

Top module: `paced_cdc_buffer`

## Requirements
- R1: While either reset is asserted, and right after it is released, `rd_valid`, `rd_data`, `rd_underflow` and `wr_overflow` are all 0.
- R2: In `PACE_FILL`, `rd_valid` stays low for as long as the read side sees fewer than DEPTH/2 stored samples (8 with the defaults). Arm happens once the level reaches DEPTH/2, and the first pulse follows between PERIOD+1 and PERIOD+6 destination clocks after the write that completes the threshold.
- R3: In `PACE_RUN`, `rd_valid` is a one-cycle pulse that repeats exactly every PERIOD (16) destination clocks, whatever the write pattern is. The machine leaves `PACE_RUN` only on reset.
- R4: Samples leave in the order they were written, and each accepted sample leaves exactly once.
- R5: When a tick finds the FIFO empty, `rd_valid` still pulses, `rd_data` keeps its previous value, and `rd_underflow` goes to 1. The flag stays at 1 until reset.
- R6: A write while the FIFO is full is dropped without disturbing the stored samples, and `wr_overflow` goes to 1 and stays there until reset.
- R7: Each pointer crosses the clock boundary as a Gray code that changes in at most one bit per source clock, through a two-stage synchroniser. No sample is corrupted when the two clocks are unrelated.
- R8: After an underflow, newly written samples are delivered in order at the same cadence, with no new fill wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source (filter) domain clock |
| wr_rst_n | input | 1 | Source domain asynchronous reset, active low |
| wr_valid | input | 1 | A sample is presented this source cycle |
| wr_data | input | DATA_W | Sample value |
| wr_overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |
| rd_clk | input | 1 | Destination (modulator) domain clock |
| rd_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| rd_valid | output | 1 | One-cycle pulse, once every PERIOD destination clocks while running |
| rd_data | output | DATA_W | Current output sample, held between pulses |
| rd_underflow | output | 1 | Sticky: a tick found the FIFO empty and the previous sample was repeated |

## Verification
The source and destination clocks run at unrelated periods. The first pattern writes one sample short of the threshold and then the completing sample. This separates a buffer that waits for half depth from one that starts as soon as any data is present. Random bursts of one to four samples with compensating idle gaps keep the level near half depth, which shows whether the pulse spacing stays fixed while arrivals are irregular and whether the order and the data come through intact. Stopping the writes, and later feeding single samples just after each pulse, produces the repeat, the sticky underflow flag and the resumption without a fill wait. An unbroken burst far longer than the depth drives the FIFO full, so dropped writes can be distinguished from corrupted storage.

// File: rtl/pcdc_pkg.sv
package pcdc_pkg;

    // Read-side pacing machine
    typedef enum logic {
        PACE_FILL = 1'b0,
        PACE_RUN  = 1'b1
    } pace_state_e;

    // Depth of every pointer resynchroniser
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pcdc_ptr_sync.sv
module pcdc_ptr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/pcdc_sample_ram.sv
module pcdc_sample_ram #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/pcdc_wr_side.sv
module pcdc_wr_side #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ADDR_W:0]   rd_gray_sync,
    output logic [ADDR_W:0]   wr_gray,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic              overflow
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wr_bin_q;
    logic [PW-1:0] wr_gray_q;
    logic [PW-1:0] wr_bin_nx;
    logic [PW-1:0] wr_gray_nx;
    logic [PW-1:0] full_pattern;
    logic          full;
    logic          accept;
    logic          ovf_q;

    // Full: the two Gray pointers differ exactly in their two top bits
    assign full_pattern = {~rd_gray_sync[PW-1:PW-2], rd_gray_sync[PW-3:0]};
    assign full         = (wr_gray_q == full_pattern);
    assign accept       = push_valid && !full;
    assign wr_bin_nx    = wr_bin_q + 1'b1;
    assign wr_gray_nx   = wr_bin_nx ^ (wr_bin_nx >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin_q  <= '0;
            wr_gray_q <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (accept) begin
                wr_bin_q  <= wr_bin_nx;
                wr_gray_q <= wr_gray_nx;
            end
            if (push_valid && full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign wr_gray   = wr_gray_q;
    assign ram_we    = accept;
    assign ram_waddr = wr_bin_q[ADDR_W-1:0];
    assign overflow  = ovf_q;

    // R6
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full) |=> ($stable(wr_bin_q) && overflow));

    // R6
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_gray_q ^ $past(wr_gray_q)) <= 1);

endmodule

// File: rtl/pcdc_rd_pacer.sv
module pcdc_rd_pacer
    import pcdc_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 4,
    parameter int PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   wr_gray_sync,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              underflow
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0]    ARM_LEVEL = PW'(DEPTH / 2);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(PERIOD - 1);

    pace_state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q;
    logic [PW-1:0]     rd_bin_q;
    logic [PW-1:0]     rd_gray_q;
    logic [PW-1:0]     rd_bin_nx;
    logic [PW-1:0]     wq_bin;
    logic [PW-1:0]     level;
    logic              empty;
    logic              arm;
    logic              tick;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              unf_q;

    // Gray to binary, one reduction per bit
    for (genvar i = 0; i < PW; i++) begin : g_gray2bin
        assign wq_bin[i] = ^wr_gray_sync[PW-1:i];
    end

    assign rd_bin_nx = rd_bin_q + 1'b1;
    assign level     = wq_bin - rd_bin_q;
    assign empty     = (rd_gray_q == wr_gray_sync);
    assign arm       = (level >= ARM_LEVEL);
    assign tick      = (state_q == PACE_RUN) && (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PACE_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm (FILL -> RUN), hold (RUN -> RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PACE_FILL: if (arm) state_d = PACE_RUN;
            PACE_RUN:  state_d = PACE_RUN;
            default:   state_d = PACE_FILL;
        endcase
    end

    // Interval counter, pointer and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rd_bin_q  <= '0;
            rd_gray_q <= '0;
            valid_q   <= 1'b0;
            data_q    <= '0;
            unf_q     <= 1'b0;
        end else begin
            valid_q <= tick;
            if (state_q == PACE_RUN) begin
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (tick) begin
                if (!empty) begin
                    data_q    <= ram_rdata;
                    rd_bin_q  <= rd_bin_nx;
                    rd_gray_q <= rd_bin_nx ^ (rd_bin_nx >> 1);
                end else begin
                    unf_q <= 1'b1;
                end
            end
        end
    end

    assign ram_raddr = rd_bin_q[ADDR_W-1:0];
    assign rd_gray   = rd_gray_q;
    assign out_valid = valid_q;
    assign out_data  = data_q;
    assign underflow = unf_q;

    // Independent spacing monitor for the pacing assertion
    logic [CNT_W:0] gap_q;
    logic           seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (out_valid) begin
            gap_q  <= (CNT_W+1)'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2
    fill_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_q == PACE_RUN));

    // R3
    pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (gap_q == (CNT_W+1)'(PERIOD)));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PACE_RUN) |=> (state_q == PACE_RUN));

    // R5
    underflow_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && empty) |=> (out_valid && $stable(out_data) && underflow));

    // R5
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R7
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_gray_q ^ $past(rd_gray_q)) <= 1);

endmodule

// File: rtl/paced_cdc_buffer.sv
module paced_cdc_buffer
    import pcdc_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 4,
    parameter int PERIOD = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_underflow
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     wr_gray_rsync;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     rd_gray_wsync;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [ADDR_W-1:0] ram_raddr;
    logic [DATA_W-1:0] ram_rdata;

    pcdc_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk          (wr_clk),
        .rst_n        (wr_rst_n),
        .push_valid   (wr_valid),
        .rd_gray_sync (rd_gray_wsync),
        .wr_gray      (wr_gray),
        .ram_we       (ram_we),
        .ram_waddr    (ram_waddr),
        .overflow     (wr_overflow)
    );

    pcdc_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wr_clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    pcdc_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (wr_gray),
        .q_out (wr_gray_rsync)
    );

    pcdc_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d_in  (rd_gray),
        .q_out (rd_gray_wsync)
    );

    pcdc_rd_pacer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD(PERIOD)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .wr_gray_sync (wr_gray_rsync),
        .ram_rdata    (ram_rdata),
        .ram_raddr    (ram_raddr),
        .rd_gray      (rd_gray),
        .out_valid    (rd_valid),
        .out_data     (rd_data),
        .underflow    (rd_underflow)
    );

endmodule

// File: tb/paced_cdc_buffer_tb.sv
module paced_cdc_buffer_tb;

    localparam int DATA_W = 24;
    localparam int ADDR_W = 4;
    localparam int PERIOD = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_overflow;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              rd_underflow;

    always #10 rd_clk = ~rd_clk;   // 50 MHz destination clock
    always #7  wr_clk = ~wr_clk;   // unrelated source clock

    paced_cdc_buffer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD(PERIOD)) u_dut (
        .wr_clk       (wr_clk),
        .wr_rst_n     (wr_rst_n),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .wr_overflow  (wr_overflow),
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_underflow (rd_underflow)
    );

    int checks = 0;
    int fails  = 0;
    int mode   = 0;            // 0 idle, 1 exact order, 2 overflow run
    logic [DATA_W-1:0] exp_q [$];
    logic [DATA_W-1:0] last_out = '0;
    logic [DATA_W-1:0] exp_val;
    int  gap_cyc   = 0;
    bit  gap_seen  = 1'b0;
    int  valid_cnt = 0;
    int  unf_events = 0;
    int  order_bad = 0;
    int  ovf_outputs = 0;
    bit  ovf_first = 1'b0;

    function automatic int exp_gap();
        return PERIOD;
    endfunction

    function automatic int arm_level();
        return DEPTH / 2;
    endfunction

    // Idle source cycles that balance a burst of len samples at one per 320 ns
    function automatic int idle_for_burst(int len, int jitter);
        return len * 22 + jitter - 1;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_beat(logic v, logic [DATA_W-1:0] d, bit track);
        @(negedge wr_clk);
        wr_valid = v;
        wr_data  = d;
        if (v && track) exp_q.push_back(d);
    endtask

    task automatic wait_rd(int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    task automatic wait_next_valid();
        int vc;
        vc = valid_cnt;
        for (int i = 0; i < 200 && valid_cnt == vc; i++) @(negedge rd_clk);
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            gap_seen = 1'b0;
            gap_cyc  = 0;
        end else begin
            gap_cyc++;
            if (rd_valid) begin
                valid_cnt++;
                if (gap_seen) check(gap_cyc == exp_gap(), "R3 pulse spacing", gap_cyc, exp_gap());
                gap_seen = 1'b1;
                gap_cyc  = 0;
                if (mode == 1) begin
                    if (exp_q.size() > 0) begin
                        exp_val = exp_q.pop_front();
                        if (rd_data != exp_val) order_bad++;
                        check(rd_data == exp_val, "R4 sample order", rd_data, exp_val);
                    end else begin
                        unf_events++;
                        check(rd_data == last_out, "R5 repeated sample", rd_data, last_out);
                        check(rd_underflow == 1'b1, "R5 underflow flag", rd_underflow, 1);
                    end
                end else if (mode == 2) begin
                    if (!ovf_first) begin
                        ovf_first   = 1'b1;
                        ovf_outputs = 1;
                        check(rd_data == DATA_W'(1000), "R6 first stored sample", rd_data, 1000);
                    end else if (rd_data != last_out) begin
                        if (ovf_outputs < DEPTH)
                            check(rd_data == last_out + 1'b1, "R6 stored run intact", rd_data, last_out + 1'b1);
                        else
                            check(rd_data > last_out, "R6 later sample newer", rd_data, last_out);
                        ovf_outputs++;
                    end
                end
                last_out = rd_data;
            end
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int seed_val;
        int first_wait;
        int blen;
        seed_val = $urandom(32'd2024);

        // R1: reset state
        wait_rd(4);
        check(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
        check(rd_underflow == 1'b0, "R1 underflow in reset", rd_underflow, 0);
        check(wr_overflow == 1'b0, "R1 overflow in reset", wr_overflow, 0);
        @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        wait_rd(2);
        check(rd_data == '0, "R1 data after reset", rd_data, 0);
        mode = 1;

        // R2: one short of the threshold stays silent
        for (int i = 0; i < arm_level() - 1; i++) wr_beat(1'b1, DATA_W'($urandom), 1'b1);
        wr_beat(1'b0, '0, 1'b0);
        wait_rd(100);
        check(valid_cnt == 0, "R2 silent below threshold", valid_cnt, 0);
        wr_beat(1'b1, DATA_W'($urandom), 1'b1);
        wr_beat(1'b0, '0, 1'b0);
        first_wait = 0;
        while (valid_cnt == 0 && first_wait < 100) begin
            @(negedge rd_clk);
            first_wait++;
        end
        check(first_wait >= exp_gap() + 1 && first_wait <= exp_gap() + 6,
              "R2 start after threshold", first_wait, exp_gap() + 3);

        // R3 R4 R7: random bursts with compensating gaps
        for (int b = 0; b < 40; b++) begin
            blen = 1 + int'($urandom % 4);
            for (int k = 0; k < blen; k++) wr_beat(1'b1, DATA_W'($urandom), 1'b1);
            wr_beat(1'b0, '0, 1'b0);
            for (int k = 0; k < idle_for_burst(blen, int'($urandom % 3)); k++) wr_beat(1'b0, '0, 1'b0);
        end
        for (int i = 0; i < 5000 && exp_q.size() > 0; i++) @(negedge rd_clk);
        check(exp_q.size() == 0, "R4 all samples delivered", exp_q.size(), 0);
        check(order_bad == 0, "R7 crossing kept data intact", order_bad, 0);
        check(rd_underflow == 1'b0, "R4 no underflow at matched rate", rd_underflow, 0);
        check(wr_overflow == 1'b0, "R4 no overflow at matched rate", wr_overflow, 0);

        // R5: writes stop, ticks repeat the last sample
        wait_rd(5 * PERIOD);
        check(unf_events >= 3, "R5 repeats while empty", unf_events, 3);
        check(rd_underflow == 1'b1, "R5 flag set", rd_underflow, 1);

        // R8: resume feeding right after pulses
        wait_next_valid();
        for (int k = 0; k < 4; k++) wr_beat(1'b1, DATA_W'($urandom), 1'b1);
        wr_beat(1'b0, '0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            wait_next_valid();
            wr_beat(1'b1, DATA_W'($urandom), 1'b1);
            wr_beat(1'b0, '0, 1'b0);
        end
        for (int i = 0; i < 2000 && exp_q.size() > 0; i++) @(negedge rd_clk);
        check(exp_q.size() == 0, "R8 resumed samples delivered", exp_q.size(), 0);
        check(rd_underflow == 1'b1, "R5 flag sticky", rd_underflow, 1);

        // R1 again, then R6: long unbroken burst
        mode = 0;
        @(negedge rd_clk);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wait_rd(3);
        check(rd_underflow == 1'b0, "R1 underflow cleared", rd_underflow, 0);
        check(rd_valid == 1'b0, "R1 valid cleared", rd_valid, 0);
        exp_q.delete();
        ovf_first = 1'b0;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        wait_rd(2);
        mode = 2;
        for (int i = 0; i < 40; i++) wr_beat(1'b1, DATA_W'(1000 + i), 1'b0);
        wr_beat(1'b0, '0, 1'b0);
        check(wr_overflow == 1'b1, "R6 overflow flag", wr_overflow, 1);
        wait_rd(30 * PERIOD);
        check(ovf_outputs >= DEPTH, "R6 stored samples all delivered", ovf_outputs, DEPTH);
        check(wr_overflow == 1'b1, "R6 overflow sticky", wr_overflow, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule